// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This unit takes an unrounded mantissa that carries two extra low-order bits, guard above round, together with a separate sticky bit, a sign bit and a 2-bit rounding-mode code. It drops the two extra bits and decides from the mode whether the kept mantissa must be bumped by one. The increment carries through the full kept width. All results are registered, so they appear one clock after the inputs.

The outputs are:
- the rounded mantissa and the carry out of its top bit;
- a rounded-up indication and a matching fraction-rounded flag;
- an inexact flag.

From the same mode table the unit also reports the overflow target for a result of the given sign: infinity, or the largest finite magnitude. A carry out of an all-ones mantissa is handed to the caller unchanged. Adjusting the exponent is left to the surrounding datapath.

Top module: `dir_round_unit`

## Requirements
- R1: The kept mantissa is `mant_i[W+1:2]`. When no increment is decided, `mant_o` equals it and `carry_o` is 0.
- R2: When guard (`mant_i[1]`), round (`mant_i[0]`) and `sticky_i` are all 0, the result is exact: `inexact_o`, `up_o` and `frac_rnd_o` are 0 and the mantissa is unchanged.
- R3: Any nonzero guard, round or sticky bit sets `inexact_o` to 1, in every mode.
- R4: Mode 00 (nearest) increments only when guard is 1 and at least one of round, sticky or the kept LSB is 1. An exact half therefore rounds to the even neighbour.
- R5: Mode 01 (toward zero) never increments.
- R6: Mode 10 (toward plus infinity) increments an inexact value only when `sign_i` is 0.
- R7: Mode 11 (toward minus infinity) increments an inexact value only when `sign_i` is 1.
- R8: On every increment, `up_o` and `frac_rnd_o` are 1 and `{carry_o, mant_o}` equals the kept mantissa plus one. An all-ones kept mantissa gives `mant_o` = 0 with `carry_o` = 1.
- R9: `ovf_inf_o` is 1 (go to infinity) in mode 00 and 0 in mode 01. In mode 10 it is 1 only when `sign_i` is 0, and in mode 11 only when `sign_i` is 1. It does not depend on the mantissa.
- R10: Every output is registered, one cycle after the inputs. While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mant_i | input | W+2 | Unrounded mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below round |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity |
| mant_o | output | W | Rounded mantissa |
| carry_o | output | 1 | Carry out of the increment |
| up_o | output | 1 | Increment applied |
| inexact_o | output | 1 | Discarded bits were nonzero |
| frac_rnd_o | output | 1 | Fraction was rounded up |
| ovf_inf_o | output | 1 | Overflow goes to infinity (1) or to the largest finite value (0) |

## Verification
Nearest mode is tried with four extra-bit patterns. Below half and the exact tie on an even LSB must not round. The exact tie on an odd LSB and the half-plus-sticky case must round, which separates real ties-to-even from a plain check of the guard bit. Each directed mode is driven with both signs and sticky-only inexactness, which shows whether the sign gating is wired the right way round. An all-ones kept mantissa exposes a carry chain that stops short. The overflow target is checked for every mode and sign against the same table.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_POS     = 2'b10,
    RM_NEG     = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      lsb_i,
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      inc_o,
  output logic      inexact_o,
  output logic      ovf_inf_o
);
  logic lossy;
  assign lossy     = guard_i | round_i | sticky_i;
  assign inexact_o = lossy;

  always_comb begin
    inc_o     = 1'b0;
    ovf_inf_o = 1'b0;
    unique case (mode_i)
      RM_NEAREST: begin
        inc_o     = guard_i & (round_i | sticky_i | lsb_i);
        ovf_inf_o = 1'b1;
      end
      RM_ZERO: begin
        inc_o     = 1'b0;
        ovf_inf_o = 1'b0;
      end
      RM_POS: begin
        inc_o     = lossy & ~sign_i;
        ovf_inf_o = ~sign_i;
      end
      RM_NEG: begin
        inc_o     = lossy & sign_i;
        ovf_inf_o = sign_i;
      end
      default: begin
        inc_o     = 1'b0;
        ovf_inf_o = 1'b0;
      end
    endcase
  end

  // an increment without lost bits would be a spurious round
  always_comb begin
    assert_inc_needs_loss_R3: assert (!inc_o || lossy);
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int unsigned W     = 56,
  parameter int unsigned CHUNK = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  localparam int unsigned NCH = (W + CHUNK - 1) / CHUNK;

  logic [NCH:0] cy;
  assign cy[0] = inc_i;

  for (genvar c = 0; c < NCH; c++) begin : g_chunk
    localparam int unsigned LO = c * CHUNK;
    localparam int unsigned HI = ((c + 1) * CHUNK > W) ? W - 1 : (c + 1) * CHUNK - 1;
    localparam int unsigned CW = HI - LO + 1;
    logic [CW:0] part;
    assign part          = {1'b0, val_i[HI:LO]} + {{CW{1'b0}}, cy[c]};
    assign sum_o[HI:LO]  = part[CW-1:0];
    assign cy[c+1]       = part[CW];
  end

  assign carry_o = cy[NCH];
endmodule

// File: rtl/dir_round_unit.sv
module dir_round_unit
  import rnd_pkg::*;
#(
  parameter int unsigned W = 56
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W+1:0] mant_i,
  input  logic         sticky_i,
  input  logic         sign_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] mant_o,
  output logic         carry_o,
  output logic         up_o,
  output logic         inexact_o,
  output logic         frac_rnd_o,
  output logic         ovf_inf_o
);
  logic [W-1:0] kept, sum;
  logic         inc, inx, ovf, cy;

  assign kept = mant_i[W+1:2];

  rnd_decide i_decide (
    .lsb_i    (mant_i[2]),
    .guard_i  (mant_i[1]),
    .round_i  (mant_i[0]),
    .sticky_i (sticky_i),
    .sign_i   (sign_i),
    .mode_i   (rnd_mode_e'(mode_i)),
    .inc_o    (inc),
    .inexact_o(inx),
    .ovf_inf_o(ovf)
  );

  rnd_incr #(.W(W)) i_incr (
    .val_i  (kept),
    .inc_i  (inc),
    .sum_o  (sum),
    .carry_o(cy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mant_o     <= '0;
      carry_o    <= 1'b0;
      up_o       <= 1'b0;
      inexact_o  <= 1'b0;
      frac_rnd_o <= 1'b0;
      ovf_inf_o  <= 1'b0;
    end else begin
      mant_o     <= sum;
      carry_o    <= cy;
      up_o       <= inc;
      inexact_o  <= inx;
      frac_rnd_o <= inc;
      ovf_inf_o  <= ovf;
    end
  end

  // set one edge after reset, so $past below only sees sampled inputs
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_exact_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mant_i[1:0] == 2'b00 && !sticky_i)
      |-> !inexact_o && !up_o && mant_o == $past(mant_i[W+1:2]));

  assert_rz_no_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i == 2'b01) |-> !up_o && !ovf_inf_o);

  assert_incr_value_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && up_o |-> {carry_o, mant_o} == {1'b0, $past(mant_i[W+1:2])} + 1'b1);

  assert_no_up_keep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !up_o |-> !carry_o && mant_o == $past(mant_i[W+1:2]));

  assert_nearest_inf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(mode_i == 2'b00) |-> ovf_inf_o);
endmodule

// File: tb/test_dir_round_unit.sv
module test_dir_round_unit;
  localparam int W = 56;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W+1:0] mant = '0;
  logic         sticky = 1'b0, sign = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] mant_q;
  logic         carry_q, up_q, inx_q, frq_q, ovf_q;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  dir_round_unit #(.W(W)) i_dir_round_unit (
    .clk_i(clk), .rst_ni(rst_n), .mant_i(mant), .sticky_i(sticky),
    .sign_i(sign), .mode_i(mode), .mant_o(mant_q), .carry_o(carry_q),
    .up_o(up_q), .inexact_o(inx_q), .frac_rnd_o(frq_q), .ovf_inf_o(ovf_q)
  );

  task automatic chk(input string req, input logic [W-1:0] em, input logic ec,
                     input logic eu, input logic ei, input logic eo);
    tests++;
    if (mant_q !== em || carry_q !== ec || up_q !== eu || frq_q !== eu ||
        inx_q !== ei || ovf_q !== eo) begin
      fails++;
      $display("FAIL %s: got m=%h c=%b u=%b f=%b i=%b o=%b exp m=%h c=%b u=%b f=%b i=%b o=%b",
               req, mant_q, carry_q, up_q, frq_q, inx_q, ovf_q, em, ec, eu, eu, ei, eo);
    end
  endtask

  task automatic drive(input logic [W-1:0] k, input logic [1:0] gr, input logic st,
                       input logic sg, input logic [1:0] md);
    @(negedge clk);
    mant = {k, gr}; sticky = st; sign = sg; mode = md;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    mant = {56'hFF, 2'b11}; sticky = 1'b1; mode = 2'b00;
    @(negedge clk);
    chk("R10 reset", '0, 0, 0, 0, 0);
  endtask

  task automatic t_exact;
    drive(56'h123, 2'b00, 0, 0, 2'b00); chk("R2 exact nearest", 56'h123, 0, 0, 0, 1);
    drive(56'h123, 2'b00, 0, 0, 2'b10); chk("R1 exact plus", 56'h123, 0, 0, 0, 1);
  endtask

  task automatic t_nearest;
    drive(56'h10, 2'b01, 0, 0, 2'b00); chk("R4 below half", 56'h10, 0, 0, 1, 1);
    drive(56'h10, 2'b00, 1, 0, 2'b00); chk("R3 sticky only", 56'h10, 0, 0, 1, 1);
    drive(56'h10, 2'b10, 0, 0, 2'b00); chk("R4 tie even", 56'h10, 0, 0, 1, 1);
    drive(56'h11, 2'b10, 0, 0, 2'b00); chk("R4 tie odd", 56'h12, 0, 1, 1, 1);
    drive(56'h10, 2'b10, 1, 1, 2'b00); chk("R4 above half", 56'h11, 0, 1, 1, 1);
  endtask

  task automatic t_zero;
    drive(56'h10, 2'b11, 1, 0, 2'b01); chk("R5 toward zero pos", 56'h10, 0, 0, 1, 0);
    drive(56'h10, 2'b11, 1, 1, 2'b01); chk("R5 toward zero neg", 56'h10, 0, 0, 1, 0);
  endtask

  task automatic t_plus;
    drive(56'h10, 2'b00, 1, 0, 2'b10); chk("R6 plus pos", 56'h11, 0, 1, 1, 1);
    drive(56'h10, 2'b01, 0, 1, 2'b10); chk("R6 plus neg", 56'h10, 0, 0, 1, 0);
  endtask

  task automatic t_minus;
    drive(56'h10, 2'b01, 0, 1, 2'b11); chk("R7 minus neg", 56'h11, 0, 1, 1, 1);
    drive(56'h10, 2'b00, 1, 0, 2'b11); chk("R7 minus pos", 56'h10, 0, 0, 1, 0);
  endtask

  task automatic t_carry;
    drive({W{1'b1}}, 2'b11, 0, 0, 2'b00); chk("R8 full carry", '0, 1, 1, 1, 1);
    drive(56'h0000_00FF_FFFF_FF, 2'b10, 1, 0, 2'b00);
    chk("R8 chunk carry", 56'h0000_0100_0000_00, 0, 1, 1, 1);
  endtask

  task automatic t_ovf;
    drive(56'h5, 2'b00, 0, 1, 2'b00); chk("R9 nearest neg", 56'h5, 0, 0, 0, 1);
    drive(56'h5, 2'b00, 0, 1, 2'b11); chk("R9 minus neg", 56'h5, 0, 0, 0, 1);
    drive(56'h5, 2'b00, 0, 0, 2'b11); chk("R9 minus pos", 56'h5, 0, 0, 0, 0);
    drive(56'h5, 2'b00, 0, 1, 2'b10); chk("R9 plus neg", 56'h5, 0, 0, 0, 0);
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog R10: got timeout exp finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_exact();
    t_nearest();
    t_zero();
    t_plus();
    t_minus();
    t_carry();
    t_ovf();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule